// File: doc/BRIEF.md
# Delayed Single-Pulse Output Channel

This block is one output channel that emits a single timed pulse on digital output A, after a programmable on-delay. A cyclic control word supplies the pulse length in microseconds, a slot value with a 3-bit load code and an update-mode bit, a software enable, an output-source select, two direct output levels and an error-clear bit. A prescaler turns the system clock into a microsecond tick, and all delay and pulse timing counts those ticks.

The sequencer goes IDLE, DELAY, PULSE, DONE. A sequence starts either on a rising edge of the software enable, or, when the channel is set to hardware gating, from a hardware-enable input once the software enable has armed it. Dropping the software enable aborts the sequence at any point. When the output source is software, the two outputs follow the direct level bits, and output B is blocked while A is requested high. Out-of-range pulse lengths, bad load codes and out-of-range delays raise status flags.

Top module: `pulse_channel`

## Requirements
- R1: After reset, outA, outB and busy are 0, and errOutVal, errLd and errSlotVal are 0.
- R2: With srcSeq=0, outA equals setA and outB equals setB AND NOT setA, in the same cycle.
- R3: With srcSeq=1, outB is 0 and outA is high only while the sequencer is in its pulse phase.
- R4: After a start, outA rises once the on-delay has run for the stored number of ticks (TICK_DIV clocks each). It then stays high for the stored duration in ticks. A delay of 0 gives a pulse that begins on the first clock after the start.
- R5: A pulse length below MIN_US (MIN_US_FAST when highSpeed=1) or above MAX_US is rejected. errOutVal then reads 1 one clock later, and the last accepted length stays in use. A valid value clears errOutVal.
- R6: Load code 3'b010 with slotValue <= MAX_US loads the on-delay. Code 3'b000 leaves the delay untouched. While a sequence is in DELAY or PULSE, no delay load takes effect.
- R7: When slotMode=0, a load is evaluated once per change of slotLoad. A code other than 000 or 010, or an out-of-range delay, sets the latched flag errLd.
- R8: When slotMode=1, the slot is evaluated on every microsecond tick. errSlotVal then shows whether the current code or value is bad, and errLd is not touched.
- R9: While errReset=1, errLd is held at 0 from the next clock on.
- R10: With hwEnMode=0, a sequence starts only on a rising edge of swEnable. After a sequence completes, keeping swEnable high starts no further pulse.
- R11: With hwEnMode=1, swEnable high only arms the channel. The sequence starts when hwEnable is 1.
- R12: Clearing swEnable during DELAY or PULSE drives outA low and busy low on the next clock.
- R13: busy is 1 exactly while the sequencer is in DELAY or PULSE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| outValue | input | CNT_W | Requested pulse length in microseconds |
| slotValue | input | CNT_W | Slot data (on-delay in microseconds) |
| slotLoad | input | 3 | Slot load code: 000 idle, 010 on-delay, others invalid |
| slotMode | input | 1 | 0 single-update, 1 permanent-update |
| swEnable | input | 1 | Software enable / start |
| srcSeq | input | 1 | 1 sequencer drives outA, 0 software drives both outputs |
| setA | input | 1 | Direct level for outA |
| setB | input | 1 | Direct level for outB |
| errReset | input | 1 | Clears and holds errLd clear |
| highSpeed | input | 1 | Lowers the minimum pulse length |
| hwEnMode | input | 1 | 1 selects hardware-enable gated start |
| hwEnable | input | 1 | Hardware enable |
| outA | output | 1 | Digital output A |
| outB | output | 1 | Digital output B |
| busy | output | 1 | Sequence in delay or pulse phase |
| errOutVal | output | 1 | Last pulse length rejected |
| errLd | output | 1 | Latched bad slot load (single-update) |
| errSlotVal | output | 1 | Bad slot in permanent-update mode |

## Verification
The bench builds the channel with TICK_DIV=2 and MAX_US=1000. The short tick keeps delays and pulses of a few microseconds to tens of clocks, so every edge of the delay and pulse windows is measured exactly within a two-clock tolerance. The reduced upper limit lets the bench reach the rejection of both an over-long pulse length and an over-long delay. The minimum lengths keep their defaults, so the bench covers the boundary shift that highSpeed causes.

// File: rtl/pulse_pkg.sv
package pulse_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_PULSE = 2'd2,
    ST_DONE  = 2'd3
  } seqState_t;

  // strobes from sequencer control to the timing datapath
  typedef struct packed {
    logic loadDelay;  // counter <= stored on-delay
    logic loadDur;    // counter <= stored pulse length
    logic countDown;  // decrement on tick
    logic running;    // DELAY or PULSE: slot loads locked
  } dpCtrl_t;

  localparam logic [2:0] LD_IDLE  = 3'b000;
  localparam logic [2:0] LD_DELAY = 3'b010;

endpackage

// File: rtl/pulse_dp.sv
module pulse_dp
  import pulse_pkg::*;
#(
  parameter int TICK_DIV    = 125,
  parameter int CNT_W       = 32,
  parameter int MAX_US      = 85_000_000,
  parameter int MIN_US      = 10,
  parameter int MIN_US_FAST = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          ctl,
  input  logic [CNT_W-1:0] outValue,
  input  logic [CNT_W-1:0] slotValue,
  input  logic [2:0]       slotLoad,
  input  logic             slotMode,
  input  logic             highSpeed,
  input  logic             errReset,
  output logic             tick,
  output logic             cntLast,
  output logic             delayZero,
  output logic             errOutVal,
  output logic             errLd,
  output logic             errSlotVal
);

  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
  localparam logic [CNT_W-1:0] MAX_V  = CNT_W'(MAX_US);
  localparam logic [CNT_W-1:0] MIN_V  = CNT_W'(MIN_US);
  localparam logic [CNT_W-1:0] MINF_V = CNT_W'(MIN_US_FAST);

  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] durReg, delayReg, cnt;
  logic [2:0]       prevLoad;
  logic             durValid, codeChanged, codeIdle, codeDelay, slotInRange;
  logic             evalSingle, evalPerm, loadOk, badSlot;
  logic [CNT_W-1:0] minLimit;

  // microsecond prescaler
  always_ff @(posedge clk) begin
    if (!rstN) preCnt <= '0;
    else if (preCnt == PRE_LAST) preCnt <= '0;
    else preCnt <= preCnt + 1'b1;
  end
  assign tick = (preCnt == PRE_LAST);

  // pulse length check and hold
  always_comb begin
    minLimit = highSpeed ? MINF_V : MIN_V;
    durValid = (outValue >= minLimit) && (outValue <= MAX_V);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      durReg    <= MIN_V;
      errOutVal <= 1'b0;
    end else begin
      errOutVal <= !durValid;
      if (durValid) durReg <= outValue;
    end
  end

  // slot decode
  always_comb begin
    codeChanged = (slotLoad != prevLoad);
    codeIdle    = (slotLoad == LD_IDLE);
    codeDelay   = (slotLoad == LD_DELAY);
    slotInRange = (slotValue <= MAX_V);
    evalSingle  = !slotMode && codeChanged;
    evalPerm    = slotMode && tick;
    badSlot     = !codeIdle && !(codeDelay && slotInRange);
    loadOk      = (evalSingle || evalPerm) && codeDelay && slotInRange && !ctl.running;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevLoad   <= LD_IDLE;
      delayReg   <= '0;
      errLd      <= 1'b0;
      errSlotVal <= 1'b0;
    end else begin
      prevLoad <= slotLoad;
      if (loadOk) delayReg <= slotValue;
      if (errReset) errLd <= 1'b0;
      else if (evalSingle && badSlot) errLd <= 1'b1;
      if (!slotMode) errSlotVal <= 1'b0;
      else if (tick) errSlotVal <= badSlot;
    end
  end

  // shared delay / pulse down-counter
  always_ff @(posedge clk) begin
    if (!rstN) cnt <= '0;
    else if (ctl.loadDelay) cnt <= delayReg;
    else if (ctl.loadDur) cnt <= durReg;
    else if (ctl.countDown && tick) cnt <= cnt - 1'b1;
  end

  assign cntLast   = (cnt == CNT_W'(1));
  assign delayZero = (delayReg == '0);

endmodule

// File: rtl/pulse_ctrl.sv
module pulse_ctrl
  import pulse_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    swEnable,
  input  logic    hwEnMode,
  input  logic    hwEnable,
  input  logic    tick,
  input  logic    cntLast,
  input  logic    delayZero,
  output dpCtrl_t ctl,
  output logic    pulseOn,
  output logic    busy
);

  seqState_t state, stateNext;
  logic swPrev, armed, rise, canStart, startReq, start, phaseEnd;

  always_comb begin
    rise     = swEnable && !swPrev;
    canStart = (state == ST_IDLE) || (state == ST_DONE);
    startReq = hwEnMode ? ((armed || rise) && swEnable && hwEnable) : rise;
    start    = canStart && startReq;
    phaseEnd = tick && cntLast;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE, ST_DONE: begin
        if (start) stateNext = delayZero ? ST_PULSE : ST_DELAY;
        else if (!swEnable) stateNext = ST_IDLE;
      end
      ST_DELAY: begin
        if (!swEnable) stateNext = ST_IDLE;
        else if (phaseEnd) stateNext = ST_PULSE;
      end
      ST_PULSE: begin
        if (!swEnable) stateNext = ST_IDLE;
        else if (phaseEnd) stateNext = ST_DONE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      swPrev <= 1'b0;
      armed  <= 1'b0;
    end else begin
      state  <= stateNext;
      swPrev <= swEnable;
      if (!swEnable || start) armed <= 1'b0;
      else if (rise) armed <= 1'b1;
    end
  end

  always_comb begin
    ctl.loadDelay = start && !delayZero;
    ctl.loadDur   = (start && delayZero) ||
                    ((state == ST_DELAY) && swEnable && phaseEnd);
    ctl.countDown = (state == ST_DELAY) || (state == ST_PULSE);
    ctl.running   = ctl.countDown;
  end

  assign pulseOn = (state == ST_PULSE);
  assign busy    = (state == ST_DELAY) || (state == ST_PULSE);

endmodule

// File: rtl/pulse_channel.sv
module pulse_channel
  import pulse_pkg::*;
#(
  parameter int TICK_DIV    = 125,
  parameter int CNT_W       = 32,
  parameter int MAX_US      = 85_000_000,
  parameter int MIN_US      = 10,
  parameter int MIN_US_FAST = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] outValue,
  input  logic [CNT_W-1:0] slotValue,
  input  logic [2:0]       slotLoad,
  input  logic             slotMode,
  input  logic             swEnable,
  input  logic             srcSeq,
  input  logic             setA,
  input  logic             setB,
  input  logic             errReset,
  input  logic             highSpeed,
  input  logic             hwEnMode,
  input  logic             hwEnable,
  output logic             outA,
  output logic             outB,
  output logic             busy,
  output logic             errOutVal,
  output logic             errLd,
  output logic             errSlotVal
);

  dpCtrl_t ctl;
  logic tick, cntLast, delayZero, pulseOn;

  pulse_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .swEnable(swEnable), .hwEnMode(hwEnMode),
    .hwEnable(hwEnable), .tick(tick), .cntLast(cntLast), .delayZero(delayZero),
    .ctl(ctl), .pulseOn(pulseOn), .busy(busy)
  );

  pulse_dp #(
    .TICK_DIV(TICK_DIV), .CNT_W(CNT_W), .MAX_US(MAX_US),
    .MIN_US(MIN_US), .MIN_US_FAST(MIN_US_FAST)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .outValue(outValue),
    .slotValue(slotValue), .slotLoad(slotLoad), .slotMode(slotMode),
    .highSpeed(highSpeed), .errReset(errReset), .tick(tick),
    .cntLast(cntLast), .delayZero(delayZero), .errOutVal(errOutVal),
    .errLd(errLd), .errSlotVal(errSlotVal)
  );

  // output source mux; B yields to A in software mode
  assign outA = srcSeq ? pulseOn : setA;
  assign outB = srcSeq ? 1'b0 : (setB && !setA);

endmodule

// File: rtl/pulse_channel_chk.sv
module pulse_channel_chk (
  input logic clk,
  input logic rstN,
  input logic srcSeq,
  input logic setA,
  input logic swEnable,
  input logic errReset,
  input logic outA,
  input logic outB,
  input logic busy,
  input logic errLd
);

  p_seq_b_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    srcSeq |-> !outB);

  p_sw_b_blocked_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!srcSeq && setA) |-> (outA && !outB));

  p_seq_a_busy_r13: assert property (@(posedge clk) disable iff (!rstN)
    (srcSeq && outA) |-> busy);

  p_abort_r12: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !swEnable) |=> (!busy && !(srcSeq && outA)));

  p_err_hold_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    errReset |=> !errLd);

  p_start_needs_sw_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> swEnable);

endmodule

bind pulse_channel pulse_channel_chk u_chk (
  .clk(clk), .rstN(rstN), .srcSeq(srcSeq), .setA(setA), .swEnable(swEnable),
  .errReset(errReset), .outA(outA), .outB(outB), .busy(busy), .errLd(errLd)
);

// File: tb/tb_pulse_channel.sv
module tb_pulse_channel;

  localparam int CNT_W = 32;

  logic clk = 1'b0, rstN = 1'b0;
  logic [CNT_W-1:0] outValue = 32'd12, slotValue = '0;
  logic [2:0] slotLoad = 3'b000;
  logic slotMode = 0, swEnable = 0, srcSeq = 0, setA = 0, setB = 0;
  logic errReset = 0, highSpeed = 0, hwEnMode = 0, hwEnable = 0;
  logic outA, outB, busy, errOutVal, errLd, errSlotVal;

  int errors = 0, checks = 0;
  int expLo[$], expHi[$];
  bit finished = 0;

  always #4 clk = ~clk;

  pulse_channel #(.TICK_DIV(2), .CNT_W(CNT_W), .MAX_US(1000)) dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chkRange(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: measures each sequencer pulse on outA and compares to the queue
  int width = 0;
  logic prevA = 0;
  always @(negedge clk) begin
    if (rstN && srcSeq) begin
      if (outA) width++;
      if (prevA && !outA) begin
        if (expLo.size() == 0) chk("R4 unexpected pulse", width, -1);
        else begin
          int lo, hi;
          lo = expLo.pop_front();
          hi = expHi.pop_front();
          chkRange("R4 pulse width", width, lo, hi);
        end
        width = 0;
      end
      prevA = outA;
    end else begin
      prevA = 0;
      width = 0;
    end
  end

  // driver: start a sequence, check the delay, push the expected width
  task automatic runPulse(input int d, input int w, input string req);
    int n = 0;
    expLo.push_back(2 * w - 1);
    expHi.push_back(2 * w);
    swEnable = 1;
    while (n < 5000) begin
      @(negedge clk);
      n++;
      if (outA) break;
    end
    if (d == 0) chk({req, " delay0"}, n, 1);
    else chkRange({req, " delay"}, n, 2 * d, 2 * d + 1);
    while (outA) @(negedge clk);
    cyc(2);
  endtask

  initial begin
    cyc(3);
    rstN = 1;
    cyc(1);
    // R1 reset state
    chk("R1 outA", outA, 0);
    chk("R1 outB", outB, 0);
    chk("R1 busy", busy, 0);
    chk("R1 errs", {errOutVal, errLd, errSlotVal}, 0);

    // R2 software source
    setA = 0; setB = 1; #1 chk("R2 B alone", {outA, outB}, 1);
    setA = 1; setB = 1; #1 chk("R2 A blocks B", {outA, outB}, 2);
    setA = 1; setB = 0; #1 chk("R2 A only", {outA, outB}, 2);
    setA = 0; setB = 0; #1 chk("R2 none", {outA, outB}, 0);

    // R3 sequencer source forces B low
    srcSeq = 1; setB = 1; cyc(1);
    chk("R3 B forced", outB, 0);
    chk("R3 A idle", outA, 0);

    // R4/R6 delay 0 then R5 range
    runPulse(0, 12, "R4");
    swEnable = 0; cyc(1);
    outValue = 5; cyc(2);
    chk("R5 below min", errOutVal, 1);
    slotLoad = 3'b010; slotValue = 4; cyc(1);
    slotLoad = 3'b000; slotValue = 20; cyc(1);
    runPulse(4, 12, "R6 delay load R5 kept");
    // R10 no restart while held high
    cyc(30);
    chk("R10 no restart busy", busy, 0);
    chk("R10 no restart outA", outA, 0);
    swEnable = 0; cyc(1);

    highSpeed = 1; outValue = 3; cyc(2);
    chk("R5 fast min ok", errOutVal, 0);
    outValue = 1001; cyc(2);
    chk("R5 above max", errOutVal, 1);
    runPulse(4, 3, "R5 last valid");
    swEnable = 0; cyc(1);

    // R7 single-update errors, R9 clear
    slotLoad = 3'b011; cyc(1);
    chk("R7 bad code", errLd, 1);
    errReset = 1; cyc(1);
    chk("R9 cleared", errLd, 0);
    slotLoad = 3'b101; cyc(2);
    chk("R9 held clear", errLd, 0);
    errReset = 0; cyc(3);
    chk("R7 once per change", errLd, 0);
    slotLoad = 3'b010; slotValue = 2000; cyc(1);
    chk("R7 delay too big", errLd, 1);
    errReset = 1; cyc(1); errReset = 0;
    slotLoad = 3'b000; cyc(1);

    // R8 permanent mode
    slotMode = 1; slotLoad = 3'b001; cyc(3);
    chk("R8 bad code", errSlotVal, 1);
    chk("R8 errLd untouched", errLd, 0);
    slotLoad = 3'b010; slotValue = 3; cyc(3);
    chk("R8 valid", errSlotVal, 0);
    slotValue = 2000; cyc(3);
    chk("R8 value too big", errSlotVal, 1);
    slotValue = 3; cyc(3);
    runPulse(3, 3, "R8 delay from permanent");
    swEnable = 0; cyc(1);
    slotMode = 0; slotLoad = 3'b000; cyc(1);

    // R13 busy through delay, R6 delay locked while running
    outValue = 20; cyc(1);
    slotLoad = 3'b010; slotValue = 6; cyc(1);
    slotLoad = 3'b000; cyc(1);
    expLo.push_back(1); expHi.push_back(1000);
    swEnable = 1; cyc(2);
    chk("R13 busy in delay", busy, 1);
    chk("R13 outA low in delay", outA, 0);
    slotLoad = 3'b010; slotValue = 1; cyc(1);
    slotLoad = 3'b000;
    while (!outA) @(negedge clk);
    cyc(5);
    // R12 abort in pulse
    swEnable = 0; cyc(1);
    chk("R12 outA low", outA, 0);
    chk("R12 busy low", busy, 0);
    cyc(2);
    runPulse(6, 20, "R6 locked delay");
    swEnable = 0; cyc(1);

    // R11 hardware gated start
    hwEnMode = 1; swEnable = 1; cyc(10);
    chk("R11 armed only", busy, 0);
    expLo.push_back(39); expHi.push_back(40);
    hwEnable = 1; cyc(1);
    chk("R11 hw start", busy, 1);
    while (busy) @(negedge clk);
    cyc(20);
    chk("R11 no rearm", busy, 0);
    chk("R11 queue drained", expLo.size(), 0);

    finished = 1;
  end

  initial begin
    int n = 0;
    while (!finished && n < 150000) begin
      @(negedge clk);
      n++;
    end
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=done", n);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule